// File: doc/BRIEF.md
# Polyphase Decimate-by-Three FIR Filter

This block takes a stream of signed samples, one per clock when `in_valid` is high, low-pass filters it and returns one result for every three accepted samples. The prototype FIR has a cutoff at a third of the Nyquist band, which removes aliases before the rate drops. The prototype is split into three sub-filters that each run at the low rate. A rotating selector (a serial-to-parallel converter) sends consecutive samples to the sub-filters. The three partial sums are added, rounded and clipped to form the output.

Because the split happens before any multiply, the block never forms the two discarded outputs out of every three. Sub-filter k holds prototype taps h[3i+k]. The sample that completes a group goes straight into sub-filter 0 during the same cycle. The coefficients are parameters that are fixed when the design is built.

Top module: `polyphase_decim3`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next edge shows `out_valid` = 0 and `out_data` = 0. Reset also empties every sub-filter history and returns the selector to the first slot of a group.
- R2: Accepted samples are counted from 0 after reset. Sample m with m mod 3 = 2 completes a group. `out_valid` is high for exactly the one cycle that follows the clock edge that accepted that sample, and is low at every other time.
- R3: A cycle with `in_valid` low accepts nothing. It does not move the selector, and `in_data` has no effect on any later result during such a cycle.
- R4: When group sample m completes, `out_data` = sat(rnd(sum over j=0..11 of h[j]·x[m-j])). x[k] for k<0 is 0. The default taps are h = -256, -512, 0, 2048, 5120, 9216, 9216, 5120, 2048, 0, -512, -256, with 15 fraction bits.
- R5: rnd adds 2^14 to the full-precision sum and then shifts right arithmetically by 15, so an exact half rounds toward plus infinity. A sum of +16384 gives 1 and a sum of -16384 gives 0.
- R6: sat clips the rounded value to the 16-bit range [-32768, 32767].
- R7: Between pulses of `out_valid`, `out_data` keeps the value of the last result.
- R8: A reset in the middle of a group discards the partial group. The first group after reset is computed with zero history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Qualifies `in_data` for this cycle |
| in_data | input | DATA_W | Signed input sample |
| out_valid | output | 1 | One-cycle pulse per decimated result |
| out_data | output | OUT_W | Signed decimated, rounded, saturated result |

## Verification
On every cycle, the assertions check the pulse timing. Each pulse follows an accepted sample that closes a group, no two pulses are adjacent, the output holds between pulses, and the selector never leaves its three states. Only the bench scenarios can show that the values are right. It compares each result with a direct-form convolution, feeds patterns tuned to hit both saturation limits and both signs of an exact half, inserts idle gaps with garbage data, and resets in the middle of a group.

// File: rtl/pdec3_pkg.sv
// Package: constants and helpers shared by the decimator sub-blocks.
// Assumes: the decimation factor is fixed at three.
package pdec3_pkg;
    localparam int DECIM   = 3;
    localparam int PHASE_W = $clog2(DECIM);

    // Integer ceiling division, used to size the sub-filters.
    function automatic int ceil_div(input int a, input int b);
        return (a + b - 1) / b;
    endfunction
endpackage

// File: rtl/pdec3_commutator.sv
// Module: rotating selector. It follows the slot of each accepted sample
// within a group of three and raises one load strobe per accepted sample.
// Sub-filter k is loaded by slot DECIM-1-k. done marks the sample that closes a group.
// Assumes: in_valid is already synchronous to clk.
module pdec3_commutator
    import pdec3_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic [DECIM-1:0]   load,
    output logic               done,
    output logic [PHASE_W-1:0] phase
);
    localparam logic [PHASE_W-1:0] LAST = PHASE_W'(DECIM - 1);

    logic [PHASE_W-1:0] phase_q;

    // Slot counter: moves only on accepted samples and wraps after the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (in_valid) begin
            phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
        end
    end

    // One load strobe per sub-filter, decoded from the slot.
    for (genvar k = 0; k < DECIM; k++) begin : g_load
        assign load[k] = in_valid && (phase_q == PHASE_W'(DECIM - 1 - k));
    end

    assign done  = in_valid && (phase_q == LAST);
    assign phase = phase_q;
endmodule

// File: rtl/pdec3_branch.sv
// Module: one low-rate sub-filter. It keeps a delay line of the samples
// routed to it and forms their dot product with taps h[DECIM*i+PH].
// With BYPASS set, the sample arriving now is tap 0 (sub-filter 0).
// Assumes: NB >= 2; taps past the end of the prototype count as zero.
module pdec3_branch
    import pdec3_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int COEF_W = 16,
    parameter int NTAPS  = 12,
    parameter int ACC_W  = 37,
    parameter int NB     = 4,
    parameter int PH     = 0,
    parameter bit BYPASS = 1'b0,
    parameter logic signed [COEF_W-1:0] H [NTAPS] = '{default: '0}
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic signed [DATA_W-1:0] din,
    output logic signed [ACC_W-1:0]  dot
);
    localparam int LINE = BYPASS ? NB - 1 : NB;

    logic signed [DATA_W-1:0] line_q [LINE];
    logic signed [DATA_W-1:0] taps   [NB];
    logic signed [ACC_W-1:0]  prod   [NB];

    // Delay line: shifts once for each sample sent to this sub-filter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINE; i++) line_q[i] <= '0;
        end else if (load) begin
            line_q[0] <= din;
            for (int i = 1; i < LINE; i++) line_q[i] <= line_q[i-1];
        end
    end

    // Tap selection: the live sample feeds tap 0 only in the bypass variant.
    if (BYPASS) begin : g_live
        assign taps[0] = din;
        for (genvar i = 1; i < NB; i++) begin : g_t
            assign taps[i] = line_q[i-1];
        end
    end else begin : g_stored
        for (genvar i = 0; i < NB; i++) begin : g_t
            assign taps[i] = line_q[i];
        end
    end

    // Products in full precision; a missing prototype tap gives zero.
    for (genvar i = 0; i < NB; i++) begin : g_mul
        if (DECIM * i + PH < NTAPS) begin : g_on
            assign prod[i] = ACC_W'(taps[i]) * ACC_W'(H[DECIM*i+PH]);
        end else begin : g_off
            assign prod[i] = '0;
        end
    end

    // Sum of products for this sub-filter.
    always_comb begin
        dot = '0;
        for (int i = 0; i < NB; i++) dot = dot + prod[i];
    end
endmodule

// File: rtl/pdec3_combine.sv
// Module: adds the sub-filter sums, rounds half toward plus infinity,
// drops FRAC fraction bits, clips to OUT_W and registers the result.
// Assumes: FRAC >= 1 and ACC_W has headroom for the sum plus the rounding constant.
module pdec3_combine
    import pdec3_pkg::*;
#(
    parameter int ACC_W = 37,
    parameter int OUT_W = 16,
    parameter int FRAC  = 15
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    done,
    input  logic signed [ACC_W-1:0] dots [DECIM],
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] out_data
);
    localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) <<< (FRAC - 1);
    localparam logic signed [ACC_W-1:0] MAXV = (ACC_W'(1) <<< (OUT_W - 1)) - ACC_W'(1);
    localparam logic signed [ACC_W-1:0] MINV = -(ACC_W'(1) <<< (OUT_W - 1));

    logic signed [ACC_W-1:0] sum_w, rnd_w, shr_w, sat_w;

    // Sum the sub-filters, then round, shift and clip.
    always_comb begin
        sum_w = '0;
        for (int k = 0; k < DECIM; k++) sum_w = sum_w + dots[k];
        rnd_w = sum_w + HALF;
        shr_w = rnd_w >>> FRAC;
        if (shr_w > MAXV)      sat_w = MAXV;
        else if (shr_w < MINV) sat_w = MINV;
        else                   sat_w = shr_w;
    end

    // Output register: loads on group completion and holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= done;
            if (done) out_data <= sat_w[OUT_W-1:0];
        end
    end
endmodule

// File: rtl/polyphase_decim3.sv
// Module: decimate-by-three low-pass FIR, built from three low-rate sub-filters.
// The rotating selector routes each sample; sub-filter 0 sees the sample that
// closes a group during the same cycle, and the result is registered one edge later.
// Assumes: H holds a prototype of NTAPS taps with FRAC fraction bits.
module polyphase_decim3
    import pdec3_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int OUT_W  = 16,
    parameter int COEF_W = 16,
    parameter int NTAPS  = 12,
    parameter int FRAC   = 15,
    parameter logic signed [COEF_W-1:0] H [NTAPS] =
        '{-256, -512, 0, 2048, 5120, 9216, 9216, 5120, 2048, 0, -512, -256}
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_data,
    output logic                     out_valid,
    output logic signed [OUT_W-1:0]  out_data
);
    localparam int NB    = ceil_div(NTAPS, DECIM);
    localparam int ACC_W = DATA_W + COEF_W + $clog2(NTAPS) + 1;

    logic [DECIM-1:0]        load_w;
    logic                    done_w;
    logic [PHASE_W-1:0]      phase_w;
    logic signed [ACC_W-1:0] dot_w [DECIM];

    pdec3_commutator u_comm (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .load     (load_w),
        .done     (done_w),
        .phase    (phase_w)
    );

    // One sub-filter per phase; only phase 0 uses the live sample.
    for (genvar k = 0; k < DECIM; k++) begin : g_br
        pdec3_branch #(
            .DATA_W (DATA_W),
            .COEF_W (COEF_W),
            .NTAPS  (NTAPS),
            .ACC_W  (ACC_W),
            .NB     (NB),
            .PH     (k),
            .BYPASS (k == 0),
            .H      (H)
        ) u_branch (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (load_w[k]),
            .din   (in_data),
            .dot   (dot_w[k])
        );
    end

    pdec3_combine #(
        .ACC_W (ACC_W),
        .OUT_W (OUT_W),
        .FRAC  (FRAC)
    ) u_comb (
        .clk       (clk),
        .rst_n     (rst_n),
        .done      (done_w),
        .dots      (dot_w),
        .out_valid (out_valid),
        .out_data  (out_data)
    );
endmodule

// File: rtl/polyphase_decim3_chk.sv
// Module: protocol checker bound to the decimator. It keeps its own count
// of accepted samples and checks pulse timing, hold and reset on every cycle.
// Assumes: used only through the bind below.
module polyphase_decim3_chk
    import pdec3_pkg::*;
#(
    parameter int OUT_W = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic                    out_valid,
    input logic signed [OUT_W-1:0] out_data,
    input logic [PHASE_W-1:0]      phase
);
    logic [1:0] cnt_q;

    // Independent count of accepted samples, modulo three.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= '0;
        else if (in_valid) cnt_q <= (cnt_q == 2'd2) ? 2'd0 : cnt_q + 2'd1;
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_data == '0));

    assert_pulse_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));

    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    assert_group_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid && cnt_q == 2'd2));

    assert_phase_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        phase < PHASE_W'(DECIM));

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_data) |-> out_valid);
endmodule

bind polyphase_decim3 polyphase_decim3_chk #(.OUT_W(OUT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_data  (out_data),
    .phase     (phase_w)
);

// File: tb/polyphase_decim3_tb.sv
module polyphase_decim3_tb;
    localparam int NT = 12;
    localparam int NV = 24;
    localparam longint HT [NT] = '{-256, -512, 0, 2048, 5120, 9216, 9216, 5120, 2048, 0, -512, -256};
    // Stimulus table: sample values and a matching idle-gap mask.
    localparam logic signed [15:0] STIM [NV] = '{
        16'sd1200, -16'sd800, 16'sd3000, 16'sd0, 16'sd32767, -16'sd32768,
        16'sd15, 16'sd7, -16'sd21000, 16'sd18000, 16'sd1, -16'sd1,
        16'sd4096, 16'sd4096, 16'sd4096, -16'sd500, 16'sd250, 16'sd9999,
        -16'sd12345, 16'sd23456, 16'sd0, 16'sd0, 16'sd77, -16'sd30000};
    localparam bit GAP [NV] = '{0,0,1,0,0,0,1,1,0,0,0,1,0,0,0,0,1,0,0,0,0,1,0,0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic signed [15:0] in_data = '0;
    logic out_valid;
    logic signed [15:0] out_data;

    int n_tests = 0;
    int n_fail = 0;
    longint hist [NT];
    int ph_m = 0;
    logic exp_v = 1'b0;
    longint exp_d = 0;

    always #2.5 clk = ~clk;

    polyphase_decim3 u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Direct-form reference: convolve, round half up, clip.
    function automatic longint model_out();
        longint acc = 0;
        for (int j = 0; j < NT; j++) acc += HT[j] * hist[j];
        acc = (acc + 16384) >>> 15;
        if (acc > 32767) acc = 32767;
        if (acc < -32768) acc = -32768;
        return acc;
    endfunction

    task automatic model_clear();
        for (int j = 0; j < NT; j++) hist[j] = 0;
        ph_m = 0; exp_v = 1'b0; exp_d = 0;
    endtask

    task automatic send(input logic signed [15:0] d);
        @(negedge clk);
        in_valid = 1'b1; in_data = d;
        for (int j = NT - 1; j > 0; j--) hist[j] = hist[j-1];
        hist[0] = d;
        if (ph_m == 2) begin exp_v = 1'b1; exp_d = model_out(); ph_m = 0; end
        else begin exp_v = 1'b0; ph_m++; end
        @(posedge clk); #1;
        chk("R2 out_valid", out_valid, exp_v);
        if (exp_v) chk("R4 out_data", out_data, exp_d);
        else       chk("R7 hold", out_data, exp_d);
    endtask

    task automatic gap(input logic signed [15:0] junk);
        @(negedge clk);
        in_valid = 1'b0; in_data = junk; exp_v = 1'b0;
        @(posedge clk); #1;
        chk("R3 no pulse on idle", out_valid, 0);
        chk("R3 idle hold", out_data, exp_d);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        chk("R1 out_valid reset", out_valid, 0);
        chk("R1 out_data reset", out_data, 0);
        @(negedge clk);
        rst_n = 1'b1;
        model_clear();
    endtask

    initial begin
        model_clear();
        do_reset();

        // Table walk: mixed samples with idle gaps carrying garbage data.
        for (int i = 0; i < NV; i++) begin
            if (GAP[i]) gap(16'sh5A5A);
            send(STIM[i]);
        end
        gap(-16'sd1);

        // R5: exact half rounds toward plus infinity.
        do_reset();
        send(0); send(0); send(8); send(0); send(0); send(0);
        chk("R5 +half rounds to 1", out_data, 1);
        do_reset();
        send(0); send(0); send(-8); send(0); send(0); send(0);
        chk("R5 -half rounds to 0", out_data, 0);

        // R6: sign-matched full-scale input clips at both ends.
        do_reset();
        for (int i = 0; i < NT; i++) send(HT[i] < 0 ? -16'sd32767 : 16'sd32767);
        chk("R6 clip high", out_data, 32767);
        do_reset();
        for (int i = 0; i < NT; i++) send(HT[i] < 0 ? 16'sd32767 : -16'sd32767);
        chk("R6 clip low", out_data, -32768);

        // R8: reset in the middle of a group discards the partial group.
        do_reset();
        send(16'sd30000); send(-16'sd30000);
        do_reset();
        send(16'sd5000); send(16'sd6000); send(16'sd7000);
        chk("R8 fresh group value", out_data, -148);
        chk("R8 fresh group pulse", out_valid, 1);
        gap(0);

        // R4: steady input reaches the filter's DC gain.
        for (int i = 0; i < 15; i++) send(16'sd1000);
        chk("R4 dc response", out_data, 953);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R2 actual=timeout expected=completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule